// File: doc/BRIEF.md
# Parallel ADC Conversion and Readout Controller

This block sits on the host side of a parallel-bus sampling converter and runs every bus transaction for it. A start request makes it pulse the convert strobe low. It then waits for the converter's busy line to drop and rise again. After that it opens a read window with chip-select and read both low, and it captures the 15-bit result: 14 sample bits plus an overrange flag in bit 14. The result is handed to the host with a single-cycle valid pulse.

Every read or write on the bus is followed by a quiet gap, set by a parameter. No new conversion may start until that gap has run. The host can also program a signed offset. The controller checks the requested value against the allowed range. It formats an accepted value as a 12-bit two's complement field with three zero bits above it, and writes it to the converter only while no conversion is running. Requests that arrive while the bus is occupied are held and served once the quiet gap has elapsed.

Top module: `adc_par_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block forces `cnv_n`, `cs_n`, `rd_n` and `wr_n` high, and `bus_oe`, `res_valid`, `ofs_err` and `ofs_cur` to zero.
- R2: A conversion drives `cnv_n` low for exactly CNV_LOW cycles. The controller then waits until `busy_n` has been seen low and has returned high, however long the converter stays busy.
- R3: `rd_n` is never low while `busy_n` is low.
- R4: A read holds `cs_n` and `rd_n` low together for exactly RD_LOW cycles. `bus_in` is captured in the last of those cycles and appears on `res_data` with `res_valid` high for one cycle. Bit 14 of the result is the overrange flag and is passed through unchanged.
- R5: `cnv_n` never falls until at least QUIET cycles have passed with both `rd_n` and `wr_n` high since the last read or write strobe.
- R6: An offset write holds `cs_n` and `wr_n` low for WR_LOW cycles, with `rd_n` and `cnv_n` high and `bus_oe` high. `bus_out` carries bits 14..12 = 000 and bits 11..0 = the offset in two's complement (+256 gives 0x0100, -512 gives 0x0E00, +1310 gives 0x051E, -1310 gives 0x0AE2).
- R7: An offset request outside -1310..+1310 inclusive produces a one-cycle `ofs_err` pulse in the cycle after the request. It causes no bus write and leaves `ofs_cur` unchanged.
- R8: A start request made while a conversion, read, write or quiet gap is in progress is held and carried out after the quiet gap has expired.
- R9: An offset write never overlaps a conversion. When an offset write and a start are both pending, the write is performed first.
- R10: `ofs_cur` shows the last offset word written to the converter and keeps it until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | One-cycle request for a conversion |
| ofs_req | input | 1 | One-cycle request to program the offset |
| ofs_val | input | OFS_IN_W | Signed offset value for the request |
| busy_n | input | 1 | Converter busy, low while converting |
| bus_in | input | 15 | Data lines read from the converter |
| cnv_n | output | 1 | Convert strobe, active low |
| cs_n | output | 1 | Chip-select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| bus_out | output | 15 | Offset word written to the converter |
| res_data | output | 15 | Last captured result, overrange in bit 14 |
| res_valid | output | 1 | One-cycle pulse when `res_data` is new |
| ofs_err | output | 1 | One-cycle pulse for a rejected offset request |
| ofs_cur | output | 15 | Offset word currently in effect |

## Verification
The hardest case to reach from the ports is an offset request and a second start request both arriving while a conversion is in flight. Both must be held, the write must land between the two conversions, and each must still honour the quiet gap. The bench gets there with a converter model that stays busy for several cycles. It fires the offset and start requests a few cycles after the first convert strobe. It then counts the results and strobe edges seen before the write strobe falls. A second run stretches the busy time well beyond the strobe widths, to show that no read starts early.

// File: rtl/adc_par_pkg.sv
// Package: shared widths, limits and sequencer states for the parallel
// ADC controller. Assumes a 15-bit converter word with a 12-bit offset field.
package adc_par_pkg;
    localparam int RES_W   = 15;             // result / bus word width
    localparam int OFS_W   = 12;             // offset field width
    localparam int OFS_PAD = RES_W - OFS_W;  // forced-zero bits above the field
    localparam int OFS_LIM = 1310;           // magnitude limit of the offset

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CNV,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_QUIET
    } seq_st_t;
endpackage

// File: rtl/adc_ofs_check.sv
// Offset range check and formatting. Purely combinational.
// Assumes IN_W >= OFS_W. It accepts values in [-OFS_LIM, +OFS_LIM] and packs
// the low OFS_W bits (two's complement) under OFS_PAD zero bits.
module adc_ofs_check
    import adc_par_pkg::*;
#(
    parameter int IN_W = 16
) (
    input  logic signed [IN_W-1:0]  val,
    output logic                    ok,
    output logic        [RES_W-1:0] word
);
    localparam logic signed [IN_W-1:0] LIM_P = IN_W'(OFS_LIM);
    localparam logic signed [IN_W-1:0] LIM_N = -LIM_P;

    // Accept only values inside the symmetric limit, bounds included.
    always_comb begin
        ok   = (val <= LIM_P) && (val >= LIM_N);
        word = {{OFS_PAD{1'b0}}, val[OFS_W-1:0]};
    end
endmodule

// File: rtl/adc_req_hold.sv
// Request holding stage. Latches start requests and accepted offset requests
// until the sequencer takes them. Rejects out-of-range offsets with a
// one-cycle error pulse. Assumes take_* are asserted only while the
// matching pending flag is set.
module adc_req_hold
    import adc_par_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             ofs_req,
    input  logic             ofs_ok,
    input  logic [RES_W-1:0] ofs_word_in,
    input  logic             take_start,
    input  logic             take_ofs,
    output logic             start_pend,
    output logic             ofs_pend,
    output logic [RES_W-1:0] ofs_word,
    output logic             ofs_err
);
    // Pending flags, latched offset word and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pend <= 1'b0;
            ofs_pend   <= 1'b0;
            ofs_word   <= '0;
            ofs_err    <= 1'b0;
        end else begin
            ofs_err <= ofs_req && !ofs_ok;
            if (start_req)
                start_pend <= 1'b1;
            else if (take_start)
                start_pend <= 1'b0;
            if (ofs_req && ofs_ok) begin
                ofs_pend <= 1'b1;
                ofs_word <= ofs_word_in;
            end else if (take_ofs) begin
                ofs_pend <= 1'b0;
            end
        end
    end

    // R7: a rejected request raises the error in the following cycle.
    a_r7_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_req && !ofs_ok) |=> ofs_err);
    // R7: a rejected request never creates a pending write.
    a_r7_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_req && !ofs_ok && !ofs_pend) |=> !ofs_pend);
    // R8: a held start stays held until the sequencer takes it.
    a_r8_start_held: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pend && !take_start) |=> start_pend);
endmodule

// File: rtl/adc_bus_seq.sv
// Bus sequencer. Runs the convert strobe, waits on busy, performs the
// read window or the offset write, and then enforces the quiet gap.
// Assumes QUIET >= 1 and all strobe widths >= 1. Offset writes take
// priority over starts when both are pending in the idle state.
module adc_bus_seq
    import adc_par_pkg::*;
#(
    parameter int CNV_LOW = 2,
    parameter int RD_LOW  = 3,
    parameter int WR_LOW  = 2,
    parameter int QUIET   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_n,
    input  logic [RES_W-1:0] bus_in,
    input  logic             start_pend,
    input  logic             ofs_pend,
    input  logic [RES_W-1:0] ofs_word,
    output logic             take_start,
    output logic             take_ofs,
    output logic             cnv_n,
    output logic             cs_n,
    output logic             rd_n,
    output logic             wr_n,
    output logic             bus_oe,
    output logic [RES_W-1:0] bus_out,
    output logic [RES_W-1:0] res_data,
    output logic             res_valid,
    output logic [RES_W-1:0] ofs_cur
);
    localparam int MAX_A = (CNV_LOW > RD_LOW) ? CNV_LOW : RD_LOW;
    localparam int MAX_B = (WR_LOW > QUIET) ? WR_LOW : QUIET;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_C + 1);
    localparam int GAP_MAX = QUIET + 1;
    localparam int GW    = $clog2(GAP_MAX + 1);

    seq_st_t       st;
    logic [CW-1:0] cnt;
    logic          seen_busy;
    logic [GW-1:0] gap_q;

    // Which pending request the idle state accepts this cycle.
    always_comb begin
        take_ofs   = (st == ST_IDLE) && ofs_pend;
        take_start = (st == ST_IDLE) && !ofs_pend && start_pend;
    end

    // Strobes decoded from the state register.
    always_comb begin
        cnv_n   = (st != ST_CNV);
        rd_n    = (st != ST_READ);
        wr_n    = (st != ST_WRITE);
        cs_n    = !((st == ST_READ) || (st == ST_WRITE));
        bus_oe  = (st == ST_WRITE);
        bus_out = ofs_cur;
    end

    // Main sequencer: state, width counter, busy tracking, capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            seen_busy <= 1'b0;
            res_data  <= '0;
            res_valid <= 1'b0;
            ofs_cur   <= '0;
        end else begin
            res_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (take_ofs) begin
                        st      <= ST_WRITE;
                        cnt     <= CW'(WR_LOW - 1);
                        ofs_cur <= ofs_word;
                    end else if (take_start) begin
                        st        <= ST_CNV;
                        cnt       <= CW'(CNV_LOW - 1);
                        seen_busy <= 1'b0;
                    end
                end
                ST_CNV: begin
                    if (!busy_n) seen_busy <= 1'b1;
                    if (cnt == '0) st <= ST_WAIT;
                    else           cnt <= cnt - 1'b1;
                end
                ST_WAIT: begin
                    if (!busy_n) begin
                        seen_busy <= 1'b1;
                    end else if (seen_busy) begin
                        st  <= ST_READ;
                        cnt <= CW'(RD_LOW - 1);
                    end
                end
                ST_READ: begin
                    if (cnt == '0) begin
                        res_data  <= bus_in;
                        res_valid <= 1'b1;
                        st        <= ST_QUIET;
                        cnt       <= CW'(QUIET - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (cnt == '0) begin
                        st  <= ST_QUIET;
                        cnt <= CW'(QUIET - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_QUIET: begin
                    if (cnt == '0) st <= ST_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Guard counter: idle-bus cycles since the last read or write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= GW'(GAP_MAX);
        else if (!rd_n || !wr_n)
            gap_q <= '0;
        else if (gap_q != GW'(GAP_MAX))
            gap_q <= gap_q + 1'b1;
    end

    // R3: no read strobe while the converter reports busy.
    a_r3_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> busy_n);
    // R4: the result-valid flag is a single-cycle pulse.
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R4: a new result appears just as the read strobe is released.
    a_r4_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (rd_n && !$past(rd_n)));
    // R5: the convert strobe falls only after the quiet gap.
    a_r5_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv_n) |-> (gap_q >= GW'(QUIET)));
    // R6: a write never coincides with a read or a conversion strobe.
    a_r6_write_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (rd_n && cnv_n));
    // R9: the write strobe stays high while converting.
    a_r9_no_write_cnv: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_n |-> wr_n);
    // R10: the offset in effect changes only when a write begins.
    a_r10_ofs_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n && $past(wr_n)) |-> $stable(ofs_cur));
endmodule

// File: rtl/adc_par_ctl.sv
// Top: parallel ADC conversion and readout controller. It joins the offset
// check, the request holding stage and the bus sequencer.
// Assumes busy_n is synchronous to clk and bus_in is stable during reads.
module adc_par_ctl
    import adc_par_pkg::*;
#(
    parameter int OFS_IN_W = 16,
    parameter int CNV_LOW  = 2,
    parameter int RD_LOW   = 3,
    parameter int WR_LOW   = 2,
    parameter int QUIET    = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_req,
    input  logic                       ofs_req,
    input  logic signed [OFS_IN_W-1:0] ofs_val,
    input  logic                       busy_n,
    input  logic        [RES_W-1:0]    bus_in,
    output logic                       cnv_n,
    output logic                       cs_n,
    output logic                       rd_n,
    output logic                       wr_n,
    output logic                       bus_oe,
    output logic        [RES_W-1:0]    bus_out,
    output logic        [RES_W-1:0]    res_data,
    output logic                       res_valid,
    output logic                       ofs_err,
    output logic        [RES_W-1:0]    ofs_cur
);
    logic             ofs_ok;
    logic [RES_W-1:0] ofs_fmt;
    logic             start_pend, ofs_pend;
    logic [RES_W-1:0] ofs_word;
    logic             take_start, take_ofs;

    adc_ofs_check #(.IN_W(OFS_IN_W)) i_check (
        .val  (ofs_val),
        .ok   (ofs_ok),
        .word (ofs_fmt)
    );

    adc_req_hold i_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .ofs_req     (ofs_req),
        .ofs_ok      (ofs_ok),
        .ofs_word_in (ofs_fmt),
        .take_start  (take_start),
        .take_ofs    (take_ofs),
        .start_pend  (start_pend),
        .ofs_pend    (ofs_pend),
        .ofs_word    (ofs_word),
        .ofs_err     (ofs_err)
    );

    adc_bus_seq #(
        .CNV_LOW (CNV_LOW),
        .RD_LOW  (RD_LOW),
        .WR_LOW  (WR_LOW),
        .QUIET   (QUIET)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_n     (busy_n),
        .bus_in     (bus_in),
        .start_pend (start_pend),
        .ofs_pend   (ofs_pend),
        .ofs_word   (ofs_word),
        .take_start (take_start),
        .take_ofs   (take_ofs),
        .cnv_n      (cnv_n),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .bus_oe     (bus_oe),
        .bus_out    (bus_out),
        .res_data   (res_data),
        .res_valid  (res_valid),
        .ofs_cur    (ofs_cur)
    );

    // R1: the strobes are idle in the first cycle after reset.
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(!rst_n) |-> (cnv_n && cs_n && rd_n && wr_n && !res_valid));
endmodule

// File: tb/test_adc_par_ctl.sv
// Self-checking bench: a converter model, a vector table walked by one loop,
// then directed tests for pending requests, long busy time and reset.
module test_adc_par_ctl;
    localparam int CNV_LOW = 2;
    localparam int RD_LOW  = 3;
    localparam int WR_LOW  = 2;
    localparam int QUIET   = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_req = 1'b0;
    logic               ofs_req = 1'b0;
    logic signed [15:0] ofs_val = '0;
    logic               busy_n;
    logic        [14:0] bus_in;
    logic cnv_n, cs_n, rd_n, wr_n, bus_oe, res_valid, ofs_err;
    logic [14:0] bus_out, res_data, ofs_cur;

    int errs = 0;
    int checks = 0;
    int conv_len = 8;
    logic [14:0] sample = '0;

    always #10 clk = ~clk;   // 50 MHz

    adc_par_ctl #(.OFS_IN_W(16), .CNV_LOW(CNV_LOW), .RD_LOW(RD_LOW),
                  .WR_LOW(WR_LOW), .QUIET(QUIET)) i_adc_par_ctl (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .ofs_req(ofs_req),
        .ofs_val(ofs_val), .busy_n(busy_n), .bus_in(bus_in), .cnv_n(cnv_n),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .bus_oe(bus_oe),
        .bus_out(bus_out), .res_data(res_data), .res_valid(res_valid),
        .ofs_err(ofs_err), .ofs_cur(ofs_cur)
    );

    // Converter model: busy low for conv_len cycles after a convert fall.
    int   bcnt = 0;
    logic cnv_q = 1'b1;
    always @(posedge clk) begin
        cnv_q <= cnv_n;
        if (!cnv_n && cnv_q) bcnt <= conv_len;
        else if (bcnt > 0)   bcnt <= bcnt - 1;
    end
    assign busy_n = (bcnt == 0);
    assign bus_in = (!cs_n && !rd_n) ? sample : 15'h0000;

    // Monitor: strobe widths, edges, gaps and pulses seen at the ports.
    int cnv_run, rd_run, wr_run, err_run;
    int cnv_w, rd_w, wr_w, err_w;
    int wr_cnt, err_cnt, rv_cnt, cnv_falls, rd_busy, gap, gap_min;
    int wr_at_rv, wr_at_cnv;
    logic [14:0] wr_word, res_last;
    logic m_cnv_p = 1'b1, m_wr_p = 1'b1;

    task automatic clr_mon();
        cnv_run = 0; rd_run = 0; wr_run = 0; err_run = 0;
        cnv_w = 0; rd_w = 0; wr_w = 0; err_w = 0;
        wr_cnt = 0; err_cnt = 0; rv_cnt = 0; cnv_falls = 0; rd_busy = 0;
        gap_min = 1000; wr_at_rv = -1; wr_at_cnv = -1;
        wr_word = '0; res_last = '0;
    endtask

    initial begin
        clr_mon();
        gap = 1000;
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (!cnv_n) cnv_run++;
            else if (cnv_run != 0) begin cnv_w = cnv_run; cnv_run = 0; end
            if (!rd_n && !cs_n) rd_run++;
            else if (rd_run != 0) begin rd_w = rd_run; rd_run = 0; end
            if (!wr_n && !cs_n && rd_n && cnv_n && bus_oe) begin
                wr_run++; wr_word = bus_out;
            end else if (wr_run != 0) begin wr_w = wr_run; wr_run = 0; end
            if (ofs_err) err_run++;
            else if (err_run != 0) begin err_w = err_run; err_run = 0; end
            if (!wr_n && m_wr_p) begin
                wr_cnt++; wr_at_rv = rv_cnt; wr_at_cnv = cnv_falls;
            end
            if (!cnv_n && m_cnv_p) begin
                cnv_falls++;
                if (gap < gap_min) gap_min = gap;
            end
            if (!rd_n || !wr_n) gap = 0; else gap++;
            if (!rd_n && !busy_n) rd_busy++;
            if (ofs_err) err_cnt++;
            if (res_valid) begin rv_cnt++; res_last = res_data; end
        end
        m_cnv_p = cnv_n;
        m_wr_p  = wr_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
    endtask

    task automatic pulse_ofs(input logic signed [15:0] v);
        @(negedge clk); ofs_req = 1'b1; ofs_val = v;
        @(negedge clk); ofs_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    typedef struct packed {
        logic               is_ofs;
        logic signed [15:0] val;
        logic        [14:0] smp;
        logic               bad;
        logic        [14:0] word;
    } vec_t;

    localparam vec_t TBL [9] = '{
        '{1'b1,  16'sd256,  15'h0000, 1'b0, 15'h0100},
        '{1'b1, -16'sd512,  15'h0000, 1'b0, 15'h0E00},
        '{1'b1,  16'sd1310, 15'h0000, 1'b0, 15'h051E},
        '{1'b1, -16'sd1310, 15'h0000, 1'b0, 15'h0AE2},
        '{1'b1,  16'sd1311, 15'h0000, 1'b1, 15'h0000},
        '{1'b1, -16'sd1311, 15'h0000, 1'b1, 15'h0000},
        '{1'b0,  16'sd0,    15'h4ABC, 1'b0, 15'h0000},
        '{1'b0,  16'sd0,    15'h1234, 1'b0, 15'h0000},
        '{1'b0,  16'sd0,    15'h3FFF, 1'b0, 15'h0000}
    };

    logic [14:0] exp_cur;
    bit done = 1'b0;

    initial begin
        exp_cur = '0;
        idle(3);
        // R1: outputs idle while reset is held.
        chk(cnv_n && cs_n && rd_n && wr_n, "R1 strobes high in reset",
            {cnv_n, cs_n, rd_n, wr_n}, 4'hF);
        chk(!bus_oe && !res_valid && !ofs_err && ofs_cur == 15'h0,
            "R1 outputs cleared in reset", {bus_oe, res_valid, ofs_err}, 0);
        rst_n = 1'b1;
        idle(2);

        // Vector table walk: offsets (R6, R7, R10) and conversions (R2-R5).
        foreach (TBL[i]) begin
            clr_mon();
            if (TBL[i].is_ofs) begin
                pulse_ofs(TBL[i].val);
                idle(40);
                if (TBL[i].bad) begin
                    chk(err_cnt == 1 && err_w == 1, "R7 error pulse", err_cnt, 1);
                    chk(wr_cnt == 0, "R7 no write on reject", wr_cnt, 0);
                    chk(ofs_cur == exp_cur, "R7 offset unchanged", ofs_cur, exp_cur);
                end else begin
                    exp_cur = TBL[i].word;
                    chk(wr_cnt == 1 && wr_w == WR_LOW, "R6 write strobe width", wr_w, WR_LOW);
                    chk(wr_word == TBL[i].word, "R6 offset word format", wr_word, TBL[i].word);
                    chk(err_cnt == 0, "R7 no error in range", err_cnt, 0);
                    chk(ofs_cur == exp_cur, "R10 offset in effect", ofs_cur, exp_cur);
                end
            end else begin
                sample = TBL[i].smp;
                pulse_start();
                idle(40);
                chk(rv_cnt == 1, "R4 one result pulse", rv_cnt, 1);
                chk(res_last == TBL[i].smp, "R4 result data and overrange bit",
                    res_last, TBL[i].smp);
                chk(cnv_w == CNV_LOW, "R2 convert strobe width", cnv_w, CNV_LOW);
                chk(rd_w == RD_LOW, "R4 read window width", rd_w, RD_LOW);
                chk(rd_busy == 0, "R3 no read while busy", rd_busy, 0);
                chk(gap_min >= QUIET, "R5 quiet gap before convert", gap_min, QUIET);
                chk(ofs_cur == exp_cur, "R10 offset kept over conversion", ofs_cur, exp_cur);
            end
        end

        // R8, R9: offset and start requested during a running conversion.
        clr_mon();
        conv_len = 10;
        sample = 15'h2222;
        pulse_start();
        idle(3);
        pulse_ofs(16'sd100);
        idle(1);
        pulse_start();
        idle(120);
        chk(rv_cnt == 2, "R8 held start served", rv_cnt, 2);
        chk(wr_cnt == 1 && wr_word == 15'h0064, "R9 pending write done", wr_word, 15'h0064);
        chk(wr_at_rv == 1 && wr_at_cnv == 1, "R9 write between conversions",
            wr_at_cnv, 1);
        chk(gap_min >= QUIET, "R5 quiet gap after write", gap_min, QUIET);
        exp_cur = 15'h0064;

        // R8: back-to-back start requests merge behind the quiet gap.
        clr_mon();
        conv_len = 8;
        pulse_start();
        idle(12);
        pulse_start();
        idle(60);
        chk(rv_cnt == 2 && cnv_falls == 2, "R8 second start after gap", rv_cnt, 2);
        chk(gap_min >= QUIET, "R5 gap between conversions", gap_min, QUIET);

        // R2, R3: long busy time holds the read back.
        clr_mon();
        conv_len = 40;
        sample = 15'h0777;
        pulse_start();
        idle(30);
        chk(rv_cnt == 0 && rd_w == 0, "R2 waits for busy end", rv_cnt, 0);
        idle(40);
        chk(rv_cnt == 1 && res_last == 15'h0777, "R2 result after long busy",
            res_last, 15'h0777);
        chk(rd_busy == 0, "R3 no read during long busy", rd_busy, 0);

        // R1, R10: reset in mid-conversion clears the offset.
        conv_len = 8;
        pulse_start();
        idle(3);
        rst_n = 1'b0;
        idle(2);
        chk(cnv_n && cs_n && rd_n && wr_n && !res_valid, "R1 reset mid-operation",
            {cnv_n, cs_n, rd_n, wr_n}, 4'hF);
        chk(ofs_cur == 15'h0, "R10 offset cleared by reset", ofs_cur, 0);
        rst_n = 1'b1;
        idle(20);
        clr_mon();
        sample = 15'h1ABC;
        pulse_start();
        idle(40);
        chk(rv_cnt == 1 && res_last == 15'h1ABC, "R4 result after reset",
            res_last, 15'h1ABC);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule